// File: doc/BRIEF.md
# SHA-512 Message Schedule Unit

This unit accelerates the SHA-512 message schedule. It works on four 64-bit message words packed into one 256-bit vector. An operation select chooses between two partial-update steps. Combined with one lane-wise addition outside the block, the two steps produce four new schedule words.

The sigma0 step adds the small sigma0 function of neighbouring words. The sigma1 step adds the small sigma1 function of later words. In the sigma1 step the upper two lanes depend on lower lanes that the same operation has just produced.

The unit accepts one operation per cycle when `in_valid` and `in_ready` are both high. It returns the updated vector with a one-cycle `out_valid` pulse exactly two cycles after acceptance. It is fully pipelined, so results come back in issue order. Lane i occupies bits [64*i+63 : 64*i] of every 256-bit vector.

Top module: `sha512_sched_unit`

## Requirements
- R1: With `op_sel`=0, result lane i (i=0,1,2) equals the incoming `dst_in` lane i plus sigma0 of the incoming `dst_in` lane i+1, both taken before any update. Sigma0(x) = rotr(x,1) ^ rotr(x,8) ^ (x>>7).
- R2: With `op_sel`=0, result lane 3 equals `dst_in` lane 3 plus sigma0 of `src_in` lane 0. Bits 64..255 of `src_in` have no effect on the result.
- R3: With `op_sel`=1, result lanes 0 and 1 equal `dst_in` lanes 0 and 1 plus sigma1 of `src_in` lanes 2 and 3 respectively. Sigma1(x) = rotr(x,19) ^ rotr(x,61) ^ (x>>6). `src_in` lanes 0 and 1 have no effect on the result.
- R4: With `op_sel`=1, result lanes 2 and 3 equal `dst_in` lanes 2 and 3 plus sigma1 of the already-updated result lanes 0 and 1 respectively.
- R5: Every addition wraps modulo 2^64 within its lane, and no carry passes into a neighbouring lane.
- R6: The value of `op_sel` captured with the operation selects the step: 0 selects the sigma0 step and 1 selects the sigma1 step.
- R7: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears on `dst_out` with `out_valid` high for exactly one cycle, two edges after acceptance. Back-to-back operations return on consecutive cycles in issue order.
- R8: While `rst` is high, and in the cycle after it is sampled, `out_valid` and `in_ready` are low and `dst_out` is zero. `in_ready` is high from the second edge after reset is released.
- R9: A cycle without acceptance produces no result: `out_valid` stays low two edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can accept an operation |
| op_sel | input | 1 | 0: sigma0 step, 1: sigma1 step |
| dst_in | input | 256 | Destination vector, four 64-bit lanes |
| src_in | input | 256 | Source vector, four 64-bit lanes |
| out_valid | output | 1 | One-cycle pulse marking a result |
| dst_out | output | 256 | Updated destination vector |

## Verification
Random vectors of both steps are compared with a bench model. This separates correct lane routing from swapped, shifted or stale-lane variants, and separates the two sigma functions from each other.

All-ones lanes force every addition to wrap. This distinguishes lane-local 64-bit sums from sums that carry into a neighbour. Repeating an operation with only the ignored source lanes changed shows whether they leak into the result.

A full 64-word schedule expansion of a padded three-byte message chains both steps across their outputs. A back-to-back burst and an idle gap expose ordering and spurious-valid faults.

// File: rtl/sha_sched_pkg.sv
package sha_sched_pkg;
  localparam int WORD_W = 64;
  localparam int LANES  = 4;

  // rotation / shift amounts of the two small sigma functions
  localparam int SG0_ROT_A = 1;
  localparam int SG0_ROT_B = 8;
  localparam int SG0_SHR   = 7;
  localparam int SG1_ROT_A = 19;
  localparam int SG1_ROT_B = 61;
  localparam int SG1_SHR   = 6;

  typedef enum logic {
    OP_MIX0 = 1'b0,
    OP_MIX1 = 1'b1
  } sched_op_e;
endpackage

// File: rtl/sched_sigma.sv
// Combinational small-sigma function: two rotations and a logical shift.
module sched_sigma #(
  parameter int WORD_W = 64,
  parameter int ROT_A  = 1,
  parameter int ROT_B  = 8,
  parameter int SHR    = 7
) (
  input  logic [WORD_W-1:0] x,
  output logic [WORD_W-1:0] y
);
  logic [WORD_W-1:0] rot_a, rot_b, shr_v;

  assign rot_a = (x >> ROT_A) | (x << (WORD_W - ROT_A));
  assign rot_b = (x >> ROT_B) | (x << (WORD_W - ROT_B));
  assign shr_v = x >> SHR;
  assign y     = rot_a ^ rot_b ^ shr_v;
endmodule

// File: rtl/sched_front.sv
// Stage 1: every lane of the sigma0 step, low half of the sigma1 step.
module sched_front
  import sha_sched_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fire,
  input  logic                    op_sel,
  input  logic [WORD_W*LANES-1:0] dst,
  input  logic [WORD_W*LANES-1:0] src,
  output logic                    s1_valid,
  output logic                    s1_op,
  output logic [WORD_W*LANES-1:0] s1_vec
);
  localparam int HALF  = LANES / 2;
  localparam int VEC_W = WORD_W * LANES;

  logic [VEC_W-1:0] nxt_vec;
  logic             unused_src;

  assign unused_src = ^src;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [WORD_W-1:0] cur, nb, s0v, sum0, sum1;

    assign cur = dst[i*WORD_W +: WORD_W];

    if (i < LANES - 1) begin : g_nb_dst
      assign nb = dst[(i+1)*WORD_W +: WORD_W];
    end else begin : g_nb_src
      assign nb = src[WORD_W-1:0];
    end

    sched_sigma #(.WORD_W(WORD_W), .ROT_A(SG0_ROT_A), .ROT_B(SG0_ROT_B), .SHR(SG0_SHR))
      u_sg0 (.x(nb), .y(s0v));
    assign sum0 = cur + s0v;

    if (i < HALF) begin : g_lo
      logic [WORD_W-1:0] s1v;
      sched_sigma #(.WORD_W(WORD_W), .ROT_A(SG1_ROT_A), .ROT_B(SG1_ROT_B), .SHR(SG1_SHR))
        u_sg1 (.x(src[(i+HALF)*WORD_W +: WORD_W]), .y(s1v));
      assign sum1 = cur + s1v;
    end else begin : g_hi
      assign sum1 = cur;  // finished by the chain stage
    end

    assign nxt_vec[i*WORD_W +: WORD_W] = (op_sel == OP_MIX1) ? sum1 : sum0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_op    <= 1'b0;
      s1_vec   <= '0;
    end else begin
      s1_valid <= fire;
      if (fire) begin
        s1_op  <= op_sel;
        s1_vec <= nxt_vec;
      end
    end
  end

  // R9: no stage-1 entry without acceptance
  p_no_capture_r9: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !s1_valid);
endmodule

// File: rtl/sched_chain.sv
// Stage 2: the chained upper half of the sigma1 step, output registers.
module sched_chain
  import sha_sched_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    s1_valid,
  input  logic                    s1_op,
  input  logic [WORD_W*LANES-1:0] s1_vec,
  output logic                    out_valid,
  output logic [WORD_W*LANES-1:0] out_vec
);
  localparam int HALF  = LANES / 2;
  localparam int VEC_W = WORD_W * LANES;

  logic [VEC_W-1:0] nxt_vec;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [WORD_W-1:0] cur;
    assign cur = s1_vec[i*WORD_W +: WORD_W];

    if (i >= HALF) begin : g_hi
      logic [WORD_W-1:0] s1v;
      sched_sigma #(.WORD_W(WORD_W), .ROT_A(SG1_ROT_A), .ROT_B(SG1_ROT_B), .SHR(SG1_SHR))
        u_sg1 (.x(s1_vec[(i-HALF)*WORD_W +: WORD_W]), .y(s1v));
      assign nxt_vec[i*WORD_W +: WORD_W] = (s1_op == OP_MIX1) ? cur + s1v : cur;
    end else begin : g_lo
      assign nxt_vec[i*WORD_W +: WORD_W] = cur;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_vec <= nxt_vec;
    end
  end

  // R3: lower lanes leave this stage untouched
  p_low_lanes_pass_r3: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_vec[HALF*WORD_W-1:0] == $past(s1_vec[HALF*WORD_W-1:0]));

  // R1: the sigma0 step is complete after stage 1
  p_mix0_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_op == OP_MIX0) |=> out_vec == $past(s1_vec));
endmodule

// File: rtl/sha512_sched_unit.sv
module sha512_sched_unit #(
  parameter int WORD_W = 64,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    op_sel,
  input  logic [WORD_W*LANES-1:0] dst_in,
  input  logic [WORD_W*LANES-1:0] src_in,
  output logic                    out_valid,
  output logic [WORD_W*LANES-1:0] dst_out
);
  localparam int VEC_W = WORD_W * LANES;

  logic             rdy_q, fire;
  logic             s1_valid, s1_op;
  logic [VEC_W-1:0] s1_vec;

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign fire     = in_valid & rdy_q;

  sched_front #(.WORD_W(WORD_W), .LANES(LANES)) u_front (
    .clk(clk), .rst(rst), .fire(fire), .op_sel(op_sel),
    .dst(dst_in), .src(src_in),
    .s1_valid(s1_valid), .s1_op(s1_op), .s1_vec(s1_vec)
  );

  sched_chain #(.WORD_W(WORD_W), .LANES(LANES)) u_chain (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_op(s1_op), .s1_vec(s1_vec),
    .out_valid(out_valid), .out_vec(dst_out)
  );

  // R7: every accepted operation yields a result two edges later
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    $past(fire, 2) |-> out_valid);

  // R7/R9: no result without an acceptance two edges earlier
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(fire, 2));
endmodule

// File: tb/test_sha512_sched_unit.sv
module test_sha512_sched_unit;
  localparam int W = 64;
  localparam int VW = 256;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          in_ready;
  logic          op_sel;
  logic [VW-1:0] dst_in, src_in;
  logic          out_valid;
  logic [VW-1:0] dst_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  sha512_sched_unit i_sha512_sched_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_sel(op_sel), .dst_in(dst_in), .src_in(src_in),
    .out_valid(out_valid), .dst_out(dst_out)
  );

  function automatic logic [W-1:0] rr(input logic [W-1:0] x, input int n);
    return (x >> n) | (x << (W - n));
  endfunction
  function automatic logic [W-1:0] sg0(input logic [W-1:0] x);
    return rr(x, 1) ^ rr(x, 8) ^ (x >> 7);
  endfunction
  function automatic logic [W-1:0] sg1(input logic [W-1:0] x);
    return rr(x, 19) ^ rr(x, 61) ^ (x >> 6);
  endfunction
  function automatic logic [W-1:0] ln(input logic [VW-1:0] v, input int i);
    return v[i*W +: W];
  endfunction

  function automatic logic [VW-1:0] model(input logic op, input logic [VW-1:0] d,
                                          input logic [VW-1:0] s);
    logic [W-1:0] r0, r1, r2, r3;
    if (!op) begin
      r0 = ln(d,0) + sg0(ln(d,1));
      r1 = ln(d,1) + sg0(ln(d,2));
      r2 = ln(d,2) + sg0(ln(d,3));
      r3 = ln(d,3) + sg0(ln(s,0));
    end else begin
      r0 = ln(d,0) + sg1(ln(s,2));
      r1 = ln(d,1) + sg1(ln(s,3));
      r2 = ln(d,2) + sg1(r0);
      r3 = ln(d,3) + sg1(r1);
    end
    return {r3, r2, r1, r0};
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // single operation: drive, check the idle cycle, then the result
  task automatic run_op(input string tag, input logic op, input logic [VW-1:0] d,
                        input logic [VW-1:0] s, output logic [VW-1:0] res);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; dst_in = d; src_in = s;
    @(negedge clk);
    in_valid = 1'b0; dst_in = '0; src_in = '0;
    chk({tag, " R7 no early valid"}, {255'd0, out_valid}, 256'd0);
    @(negedge clk);
    chk({tag, " R7 valid"}, {255'd0, out_valid}, 256'd1);
    res = dst_out;
    chk(tag, dst_out, model(op, d, s));
  endtask

  logic [VW-1:0] r, r2, d, s, da, sa, db, sb, dc, sc;
  logic [W-1:0]  wv [80];
  logic [W-1:0]  wr [80];
  int seed_val;

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    seed_val = $urandom(32'h5EED_0512);
    rst = 1'b1; in_valid = 1'b0; op_sel = 1'b0; dst_in = '0; src_in = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 out_valid", {255'd0, out_valid}, 256'd0);
    chk("R8 dst_out", dst_out, 256'd0);
    chk("R8 in_ready", {255'd0, in_ready}, 256'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 ready after reset", {255'd0, in_ready}, 256'd1);

    // R9: idle cycles give no result
    repeat (3) @(negedge clk);
    chk("R9 idle", {255'd0, out_valid}, 256'd0);

    // R1/R2/R3/R4/R6: random operations of both kinds
    for (int k = 0; k < 40; k++) begin
      d = rnd_vec(); s = rnd_vec();
      if (k[0]) run_op("R3 R4 R6 random sigma1 step", 1'b1, d, s, r);
      else      run_op("R1 R2 R6 random sigma0 step", 1'b0, d, s, r);
    end

    // R5: all-ones lanes force wrap-around in every lane
    d = {VW{1'b1}}; s = {VW{1'b1}};
    run_op("R5 wrap sigma0 step", 1'b0, d, s, r);
    run_op("R5 wrap sigma1 step", 1'b1, d, s, r);
    d = {64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0};
    s = {64'h1, 64'h0, 64'h8000_0000_0000_0000, 64'h1};
    run_op("R5 mixed carry lanes", 1'b1, d, s, r);

    // R2: source bits above lane 0 are ignored by the sigma0 step
    d = rnd_vec(); s = rnd_vec();
    run_op("R2 base", 1'b0, d, s, r);
    run_op("R2 upper src changed", 1'b0, d, {~s[VW-1:W], s[W-1:0]}, r2);
    chk("R2 upper src ignored", r2, r);

    // R3: source lanes 0 and 1 are ignored by the sigma1 step
    run_op("R3 base", 1'b1, d, s, r);
    run_op("R3 low src changed", 1'b1, d, {s[VW-1:2*W], ~s[2*W-1:0]}, r2);
    chk("R3 low src ignored", r2, r);

    // R7: back-to-back burst returns in order on consecutive cycles
    da = rnd_vec(); sa = rnd_vec(); db = rnd_vec(); sb = rnd_vec();
    dc = rnd_vec(); sc = rnd_vec();
    @(negedge clk); in_valid = 1'b1; op_sel = 1'b1; dst_in = da; src_in = sa;
    @(negedge clk); op_sel = 1'b0; dst_in = db; src_in = sb;
    @(negedge clk); op_sel = 1'b1; dst_in = dc; src_in = sc;
    chk("R7 burst first", {dst_out[VW-2:0], out_valid}, {model(1'b1, da, sa)[VW-2:0], 1'b1});
    chk("R7 burst first full", dst_out, model(1'b1, da, sa));
    @(negedge clk); in_valid = 1'b0;
    chk("R7 burst second", dst_out, model(1'b0, db, sb));
    chk("R7 burst second valid", {255'd0, out_valid}, 256'd1);
    @(negedge clk);
    chk("R7 burst third", dst_out, model(1'b1, dc, sc));
    chk("R7 burst third valid", {255'd0, out_valid}, 256'd1);
    @(negedge clk);
    chk("R7 R9 valid is a pulse", {255'd0, out_valid}, 256'd0);

    // R1..R5: full schedule expansion of a padded three-byte message
    for (int t = 0; t < 16; t++) wv[t] = 64'h0;
    wv[0] = 64'h6162_6380_0000_0000;
    wv[15] = 64'h18;
    for (int t = 0; t < 16; t++) wr[t] = wv[t];
    for (int t = 16; t < 80; t++)
      wr[t] = sg1(wr[t-2]) + wr[t-7] + sg0(wr[t-15]) + wr[t-16];
    for (int t = 16; t < 80; t += 4) begin
      d = {wv[t-13], wv[t-14], wv[t-15], wv[t-16]};
      s = {192'd0, wv[t-12]};
      run_op("R1 R2 schedule sigma0 step", 1'b0, d, s, r);
      for (int i = 0; i < 4; i++) r[i*W +: W] = r[i*W +: W] + wv[t-7+i];
      s = {wv[t-1], wv[t-2], wv[t-3], wv[t-4]};
      run_op("R3 R4 schedule sigma1 step", 1'b1, r, s, r2);
      for (int i = 0; i < 4; i++) wv[t+i] = r2[i*W +: W];
      chk("R4 schedule words", {wv[t+3], wv[t+2], wv[t+1], wv[t]},
          {wr[t+3], wr[t+2], wr[t+1], wr[t]});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule